// File: doc/BRIEF.md
# Interrupt-Driven Banked Register Context

This block holds several complete sets of working registers. Each set contains eight general registers, two accumulators, a repeat counter and a seven-bit group of arithmetic control flags. Set 0 is the default set. A parameter sets the number of alternate sets, from 0 to 7. A 3-bit context value selects which set the register port reads and writes.

When an interrupt is taken, the block saves the current context on an internal stack. It then moves to the set whose number equals the interrupt's priority level, if that set exists. A return from interrupt pops the saved context, so nested routines unwind in the reverse order of entry. A trap, which is an exception above every interrupt level, also saves the context but leaves the active set unchanged. Software can jump directly to any implemented set with a swap command. A later exception saves the swapped value.

Every set keeps its contents when the block moves to another set. As a result, interrupt handlers need no save and restore code for their own registers.

Top module: `ctx_bank_regfile`

## Requirements
- R1: After reset, ctx_out is 0, every register of every set reads 0, and the context stack is empty.
- R2: Register addresses: 0 to 7 are the general registers, 8 and 9 are the two accumulators, 10 is the repeat counter, and 11 is the control flags. Address 11 stores only wr_data[6:0] and reads 0 in bits above bit 6. Addresses 12 to 15 read 0 and ignore writes. rd_data shows the addressed register of the active set in the same cycle.
- R3: A write changes only the addressed register of the active set. Changing context never alters any register of any set.
- R4: irq_enter with irq_level from 1 to NUM_ALT pushes ctx_out and sets ctx_out to irq_level on the next cycle. A level of 0 or above NUM_ALT pushes ctx_out and keeps it unchanged.
- R5: irq_return pops the stack into ctx_out. Nested entries at levels 1, 4 and 5 give contexts 0→1→4→5, and three returns give 5→4→1→0.
- R6: trap_enter pushes ctx_out and leaves ctx_out unchanged.
- R7: swap_en sets ctx_out to swap_ctx when swap_ctx is at most NUM_ALT, and does not touch the stack. A swap_ctx above NUM_ALT is ignored. A later exception pushes the swapped value.
- R8: irq_return with an empty stack sets ctx_out to 0.
- R9: A write issued in the same cycle as a context change goes to the set that was active before the change. Reads in later cycles return data from the new set.
- R10: When several events are asserted in one cycle, only one is performed. The order of precedence is trap_enter, then irq_enter, then irq_return, then swap_en.
- R11: The stack holds STK_DEPTH entries. A push onto a full stack is discarded. Pops then return the stored entries, newest first, followed by 0 once the stack is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write register address |
| wr_data | input | DW | Write data |
| rd_addr | input | 4 | Read register address |
| rd_data | output | DW | Read data from the active set |
| irq_enter | input | 1 | Interrupt entry strobe |
| irq_level | input | 3 | Priority level of the interrupt being entered |
| trap_enter | input | 1 | Trap entry strobe |
| irq_return | input | 1 | Return-from-exception strobe |
| swap_en | input | 1 | Software context swap strobe |
| swap_ctx | input | 3 | Target context for a swap |
| ctx_out | output | 3 | Current context identifier |

## Verification
The bench builds the block with NUM_ALT = 5, STK_DEPTH = 8 and DW = 16. With five alternate sets, levels 6 and 7 have no set, so the bench can exercise both the level-to-set mapping and the stay-in-place case. It can also try a swap to an unimplemented set. With an eight-entry stack, the bench can fill the stack, attempt a ninth push, and then pop past empty within a short run. Simultaneous events and writes in the cycle of a context change are checked against a reference model kept in the bench.

// File: rtl/ctxb_pkg.sv
package ctxb_pkg;
  localparam int unsigned CTX_W     = 3;
  localparam int unsigned ADDR_W    = 4;
  localparam int unsigned NREG      = 12;
  localparam int unsigned ADDR_CTRL = 11;
  localparam int unsigned CTRL_W    = 7;
  typedef logic [CTX_W-1:0]  ctx_t;
  typedef logic [ADDR_W-1:0] addr_t;
endpackage

// File: rtl/ctxb_rst_sync.sv
module ctxb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/ctxb_stack.sv
module ctxb_stack
  import ctxb_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic pop,
  input  ctx_t din,
  output ctx_t top,
  output logic empty
);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [CW-1:0] cnt_q, cnt_nxt;
  logic          cnt_en, full, push_ok, pop_ok;
  ctx_t          mem_q [DEPTH];
  logic [CW-1:0] top_idx;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty && !push;

  always_comb begin
    cnt_nxt = cnt_q;
    if (push_ok)     cnt_nxt = cnt_q + 1'b1;
    else if (pop_ok) cnt_nxt = cnt_q - 1'b1;
  end
  assign cnt_en = push_ok || pop_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_nxt;
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           mem_q[e] <= '0;
      else if (push_ok && cnt_q == CW'(e))  mem_q[e] <= din;
    end
  end

  assign top_idx = cnt_q - 1'b1;
  always_comb begin
    top = '0;
    for (int e = 0; e < DEPTH; e++)
      if (!empty && top_idx[AW-1:0] == AW'(e)) top = mem_q[e];
  end

  // R11: occupancy never exceeds the depth, and a push onto a full stack leaves it full
  p_depth_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  p_full_push_dropped_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |=> full);
endmodule

// File: rtl/ctxb_ctrl.sv
module ctxb_ctrl
  import ctxb_pkg::*;
#(
  parameter int unsigned NUM_ALT = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trap_enter,
  input  logic irq_enter,
  input  ctx_t irq_level,
  input  logic irq_return,
  input  logic swap_en,
  input  ctx_t swap_ctx,
  input  ctx_t stk_top,
  input  logic stk_empty,
  output logic stk_push,
  output logic stk_pop,
  output ctx_t ctx_o
);
  localparam ctx_t MAX_CTX = ctx_t'(NUM_ALT);

  ctx_t ctx_q, ctx_nxt;
  logic ctx_en;
  logic lvl_valid, swap_valid;

  assign lvl_valid  = (irq_level != '0) && (irq_level <= MAX_CTX);
  assign swap_valid = (swap_ctx <= MAX_CTX);

  always_comb begin
    ctx_nxt  = ctx_q;
    stk_push = 1'b0;
    stk_pop  = 1'b0;
    if (trap_enter) begin
      stk_push = 1'b1;
    end else if (irq_enter) begin
      stk_push = 1'b1;
      if (lvl_valid) ctx_nxt = irq_level;
    end else if (irq_return) begin
      stk_pop = 1'b1;
      ctx_nxt = stk_empty ? '0 : stk_top;
    end else if (swap_en && swap_valid) begin
      ctx_nxt = swap_ctx;
    end
  end

  assign ctx_en = (ctx_nxt != ctx_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctx_q <= '0;
    else if (ctx_en) ctx_q <= ctx_nxt;
  end

  assign ctx_o = ctx_q;

  // R4: an implemented level selects its own set
  p_level_selects_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_enter && !trap_enter && irq_level != '0 && irq_level <= MAX_CTX)
      |=> (ctx_o == $past(irq_level)));
  // R6: a trap keeps the active set
  p_trap_keeps_ctx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_enter |=> $stable(ctx_o));
  // R7: a swap to an unimplemented set is ignored
  p_bad_swap_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_en && !trap_enter && !irq_enter && !irq_return && swap_ctx > MAX_CTX)
      |=> $stable(ctx_o));
  // R8: a return with nothing stacked lands in set 0
  p_empty_pop_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_return && !trap_enter && !irq_enter && stk_empty) |=> (ctx_o == '0));
  // R10: an entry and a pop never happen together
  p_one_stack_op_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(stk_push && stk_pop));
  // R4: context never names an unimplemented set
  p_ctx_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_o <= MAX_CTX);
endmodule

// File: rtl/ctxb_bank.sv
module ctxb_bank
  import ctxb_pkg::*;
#(
  parameter int unsigned NUM_ALT = 7,
  parameter int unsigned DW      = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctx_t          ctx,
  input  logic          we,
  input  addr_t         waddr,
  input  logic [DW-1:0] wdata,
  input  addr_t         raddr,
  output logic [DW-1:0] rdata
);
  localparam int unsigned NSETS = NUM_ALT + 1;

  logic [DW-1:0] regs_q [NSETS][NREG];

  for (genvar s = 0; s < NSETS; s++) begin : g_set
    for (genvar r = 0; r < NREG; r++) begin : g_reg
      logic sel;
      logic [DW-1:0] d;
      assign sel = we && (ctx == ctx_t'(s)) && (waddr == addr_t'(r));
      if (r == ADDR_CTRL) begin : g_ctrl
        assign d = {{(DW-CTRL_W){1'b0}}, wdata[CTRL_W-1:0]};
      end else begin : g_plain
        assign d = wdata;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   regs_q[s][r] <= '0;
        else if (sel) regs_q[s][r] <= d;
      end
      // R3: a register keeps its value unless its own set and address are written
      p_persist_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && ctx == ctx_t'(s) && waddr == addr_t'(r)) |=> $stable(regs_q[s][r]));
    end
  end

  always_comb begin
    rdata = '0;
    for (int s = 0; s < NSETS; s++)
      for (int r = 0; r < NREG; r++)
        if (ctx == ctx_t'(s) && raddr == addr_t'(r)) rdata = regs_q[s][r];
  end

  // R2: the flag register never holds bits above its width
  p_ctrl_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (raddr == addr_t'(ADDR_CTRL)) |-> (rdata[DW-1:CTRL_W] == '0));
endmodule

// File: rtl/ctx_bank_regfile.sv
module ctx_bank_regfile
  import ctxb_pkg::*;
#(
  parameter int unsigned NUM_ALT   = 7,
  parameter int unsigned STK_DEPTH = 8,
  parameter int unsigned DW        = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [3:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [3:0]    rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          irq_enter,
  input  logic [2:0]    irq_level,
  input  logic          trap_enter,
  input  logic          irq_return,
  input  logic          swap_en,
  input  logic [2:0]    swap_ctx,
  output logic [2:0]    ctx_out
);
  logic rst_sync_n;
  logic stk_push, stk_pop, stk_empty;
  ctx_t stk_top, ctx;

  ctxb_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ctxb_ctrl #(.NUM_ALT(NUM_ALT)) i_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .trap_enter (trap_enter),
    .irq_enter  (irq_enter),
    .irq_level  (irq_level),
    .irq_return (irq_return),
    .swap_en    (swap_en),
    .swap_ctx   (swap_ctx),
    .stk_top    (stk_top),
    .stk_empty  (stk_empty),
    .stk_push   (stk_push),
    .stk_pop    (stk_pop),
    .ctx_o      (ctx)
  );

  ctxb_stack #(.DEPTH(STK_DEPTH)) i_stack (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .push  (stk_push),
    .pop   (stk_pop),
    .din   (ctx),
    .top   (stk_top),
    .empty (stk_empty)
  );

  ctxb_bank #(.NUM_ALT(NUM_ALT), .DW(DW)) i_bank (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .ctx   (ctx),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  assign ctx_out = ctx;
endmodule

// File: tb/test_ctx_bank_regfile.sv
`timescale 1ns/100ps
module test_ctx_bank_regfile;
  localparam int NA = 5;
  localparam int SD = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 0, irq_enter = 0, trap_enter = 0, irq_return = 0, swap_en = 0;
  logic [3:0] wr_addr = 0, rd_addr = 0;
  logic [15:0] wr_data = 0, rd_data;
  logic [2:0] irq_level = 0, swap_ctx = 0, ctx_out;

  always #4 clk = ~clk;

  ctx_bank_regfile #(.NUM_ALT(NA), .STK_DEPTH(SD), .DW(16)) i_ctx_bank_regfile (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq_enter(irq_enter), .irq_level(irq_level),
    .trap_enter(trap_enter), .irq_return(irq_return), .swap_en(swap_en),
    .swap_ctx(swap_ctx), .ctx_out(ctx_out));

  typedef struct {
    bit          is_reg;
    logic [3:0]  addr;
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // reference model
  logic [15:0] mem [NA+1][12];
  int m_ctx = 0;
  int m_stk[$];

  always begin
    @(negedge clk);
    #2;
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      if (it.is_reg) begin
        rd_addr = it.addr;
        #1;
        n_cmp++;
        if (rd_data !== it.exp) begin
          n_bad++;
          $display("FAIL %s: rd_data[%0d] actual %h expected %h", it.tag, it.addr, rd_data, it.exp);
        end
      end else begin
        n_cmp++;
        if (ctx_out !== it.exp[2:0]) begin
          n_bad++;
          $display("FAIL %s: ctx_out actual %0d expected %0d", it.tag, ctx_out, it.exp[2:0]);
        end
      end
    end
  end

  task automatic m_push();
    if (m_stk.size() < SD) m_stk.push_back(m_ctx);
  endtask

  task automatic step(input bit tr, input bit ir, input int lvl, input bit rt,
                      input bit sw, input int sc, input bit we, input int wa, input int wd);
    trap_enter = tr; irq_enter = ir; irq_level = 3'(lvl); irq_return = rt;
    swap_en = sw; swap_ctx = 3'(sc); wr_en = we; wr_addr = 4'(wa); wr_data = 16'(wd);
    if (we && wa < 12) mem[m_ctx][wa] = (wa == 11) ? (16'(wd) & 16'h007F) : 16'(wd);
    if (tr) m_push();
    else if (ir) begin
      m_push();
      if (lvl >= 1 && lvl <= NA) m_ctx = lvl;
    end else if (rt) begin
      if (m_stk.size() == 0) m_ctx = 0;
      else m_ctx = m_stk.pop_back();
    end else if (sw && sc <= NA) m_ctx = sc;
    @(negedge clk);
    trap_enter = 0; irq_enter = 0; irq_return = 0; swap_en = 0; wr_en = 0;
  endtask

  task automatic wr(input int a, input int d);
    step(0, 0, 0, 0, 0, 0, 1, a, d);
  endtask
  task automatic irq(input int l);  step(0, 1, l, 0, 0, 0, 0, 0, 0); endtask
  task automatic ret();             step(0, 0, 0, 1, 0, 0, 0, 0, 0); endtask
  task automatic trap();            step(1, 0, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic swp(input int c);  step(0, 0, 0, 0, 1, c, 0, 0, 0); endtask

  task automatic chk_ctx(input string tag);
    item_t it;
    it.is_reg = 0; it.addr = 0; it.exp = 16'(m_ctx); it.tag = tag;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic chk_reg(input int a, input string tag);
    item_t it;
    it.is_reg = 1; it.addr = 4'(a); it.tag = tag;
    it.exp = (a < 12) ? mem[m_ctx][a] : 16'h0000;
    q.push_back(it);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s <= NA; s++)
      for (int r = 0; r < 12; r++) mem[s][r] = 16'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk_ctx("R1 reset ctx");
    chk_reg(0, "R1 reset W0");
    chk_reg(11, "R1 reset flags");

    // R2: register map in set 0
    for (int a = 0; a < 16; a++) wr(a, 16'hA000 + a * 16'h0111);
    wr(11, 16'hFFFF);
    for (int a = 0; a < 16; a++) chk_reg(a, "R2 map set0");

    // R4/R3: enter level 1, new set is still clear, then fill it
    irq(1);
    chk_ctx("R4 level1");
    chk_reg(0, "R3 set1 untouched");
    for (int a = 0; a < 12; a++) wr(a, 16'h1100 + a);
    chk_reg(5, "R3 set1 write");
    // R5: nesting 1 -> 4 -> 5 and unwind
    irq(4);  chk_ctx("R5 nest to 4");
    wr(2, 16'h4242);
    irq(5);  chk_ctx("R5 nest to 5");
    ret();   chk_ctx("R5 back to 4");
    chk_reg(2, "R3 set4 kept");
    ret();   chk_ctx("R5 back to 1");
    chk_reg(5, "R3 set1 kept");
    ret();   chk_ctx("R5 back to 0");
    chk_reg(3, "R3 set0 kept");

    // R4: levels with no set, and level 0
    irq(6);  chk_ctx("R4 level6 stays");
    irq(0);  chk_ctx("R4 level0 stays");
    ret();   chk_ctx("R4 pop after level0");
    ret();   chk_ctx("R4 pop after level6");

    // R6: trap in set 4
    irq(4);
    trap();  chk_ctx("R6 trap keeps");
    chk_reg(2, "R6 trap set4 data");
    ret();   chk_ctx("R6 trap return");
    ret();   chk_ctx("R6 back to 0");

    // R7: swaps
    swp(3);  chk_ctx("R7 swap to 3");
    swp(7);  chk_ctx("R7 swap to 7 ignored");
    irq(2);  chk_ctx("R7 irq from swapped");
    ret();   chk_ctx("R7 stacked swapped value");

    // R8: pop empty
    ret();   chk_ctx("R8 empty pop from 3");
    ret();   chk_ctx("R8 empty pop again");

    // R9: write in the switch cycle
    step(0, 1, 1, 0, 0, 0, 1, 2, 16'hBEEF);
    chk_ctx("R9 switched");
    chk_reg(2, "R9 set1 not written");
    ret();
    chk_reg(2, "R9 set0 got write");

    // R10: simultaneous events
    swp(2);
    step(1, 1, 4, 0, 0, 0, 0, 0, 0);  chk_ctx("R10 trap over irq");
    step(0, 1, 5, 1, 0, 0, 0, 0, 0);  chk_ctx("R10 irq over return");
    step(0, 0, 0, 1, 1, 4, 0, 0, 0);  chk_ctx("R10 return over swap");
    ret();  chk_ctx("R10 unwind");
    ret();  chk_ctx("R10 empty");

    // R11: overflow
    for (int i = 0; i < 9; i++) begin
      swp((i % NA) + 1);
      trap();
    end
    chk_ctx("R11 after fills");
    for (int i = 0; i < 10; i++) begin
      ret();
      chk_ctx("R11 unwind order");
    end

    repeat (3) @(negedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule